// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the target side of the SMBus alert mechanism. A local fault request marks an alert as pending and pulls the open-drain ALERT line low. The bus controller then reads from the broadcast alert response address. The block acknowledges that read only while its alert is pending, and it returns its own 7-bit address in the following data byte.

Several targets may answer the same broadcast at once. While sending its address byte, the block compares each bit it leaves released with the bus level. As soon as another target pulls a released bit low, it drops out. The target with the lowest address therefore wins, and a losing target keeps ALERT asserted for a later round. A target that sends its whole byte clears its pending alert and releases ALERT.

SCL and SDA are sampled on a fast system clock through two-flop synchronizers. START and STOP are decoded from the synchronized lines, and the block only changes its SDA drive while SCL is low.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset, alert_drive_o and sda_oe_o are both 0.
- R2: A cycle with alert_req_i high makes the alert pending, and alert_drive_o is 1 from the next clock edge.
- R3: With an alert pending, the address byte 8'h19 (7-bit address 0001100 followed by R/W = 1) is acknowledged: SDA is pulled low during the ninth clock.
- R4: With no alert pending, or with R/W = 0 (8'h18), or with any other address byte, no acknowledge is given and SDA is never driven.
- R5: After the acknowledge, the data byte carries own_addr_i in bits 7:1 and 0 in bit 0, sent MSB first. A 0 bit is driven low and a 1 bit is released.
- R6: If the block releases SDA for a 1 and reads SDA low while SCL is high, it stops driving SDA until the next START or STOP, and the alert stays pending.
- R7: When all eight data bits are sent without loss, the pending alert clears and alert_drive_o falls, whatever ACK/NACK the controller then gives. This is the only way the alert clears.
- R8: A STOP or a repeated START in the middle of a byte ends the response. SDA is released and the alert stays pending. A complete alert response read after a repeated START is answered normally.
- R9: An alert request that arrives during the acknowledge or the data byte keeps the alert pending after that response wins.
- R10: sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| alert_req_i | input | 1 | Local fault request, level or pulse |
| own_addr_i | input | 7 | Address returned in the alert response |
| alert_drive_o | output | 1 | 1 pulls the ALERT line low (open drain) |

## Verification
The assertions assume that the controller never generates a STOP or START while this block pulls SDA low. They also assume that each SCL phase lasts longer than the synchronizer and edge-detect latency of about four system clocks. Under those conditions, a drive change can only follow a sampled SCL fall.

The stimulus keeps every SCL quarter phase at five system clocks. It changes SDA only while SCL is low, except for deliberate START and STOP conditions. Mid-byte aborts use an own address of all ones, so that the block has SDA released at the moment of the abort. Competing responders are modelled on the shared wired-AND line with the same timing.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100;
  localparam logic [BYTE_W-1:0] ARA_READ = {ARA_ADDR, 1'b1};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_TX,
    ST_WAIT
  } resp_state_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  // idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] line_s;
  logic       scl_d_q, sda_d_q;

  smb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= line_s[1];
      sda_d_q <= line_s[0];
    end
  end

  assign scl_s_o    = line_s[1];
  assign sda_s_o    = line_s[0];
  assign scl_rise_o = line_s[1] & ~scl_d_q;
  assign scl_fall_o = ~line_s[1] & scl_d_q;
  assign start_o    = line_s[1] & scl_d_q & sda_d_q & ~line_s[0];
  assign stop_o     = line_s[1] & scl_d_q & ~sda_d_q & line_s[0];
endmodule

// File: rtl/smb_resp_fsm.sv
module smb_resp_fsm
  import smb_alert_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              pending_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic              win_o
);
  resp_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic              oe_q;
  logic              byte_done, lose_bit;

  assign byte_done = (cnt_q == CNT_W'(BYTE_W));
  assign lose_bit  = (state_q == ST_TX) && scl_rise_i && !oe_q && !sda_s_i;
  assign win_o     = (state_q == ST_TX) && scl_fall_i && byte_done && !start_i && !stop_i;
  assign busy_o    = (state_q == ST_ACK) || (state_q == ST_TX);
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise_i && !byte_done) begin
            rx_q  <= {rx_q[BYTE_W-2:0], sda_s_i};
            cnt_q <= cnt_q + 1'b1;
          end
          if (scl_fall_i && byte_done) begin
            if (rx_q == ARA_READ && pending_i) begin
              state_q <= ST_ACK;
              oe_q    <= 1'b1;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            state_q <= ST_TX;
            cnt_q   <= '0;
            tx_q    <= {own_addr_i, 1'b0};
            oe_q    <= ~own_addr_i[ADDR_W-1];
          end
        end
        ST_TX: begin
          if (lose_bit) begin
            state_q <= ST_WAIT;
            oe_q    <= 1'b0;
          end else if (scl_rise_i) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall_i) begin
            if (byte_done) begin
              state_q <= ST_WAIT;
              oe_q    <= 1'b0;
            end else begin
              oe_q <= ~tx_q[BYTE_W-2];
              tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R10: drive only moves after SCL was seen low
  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s_i));

  // R6: a lost bit ends all driving
  p_lost_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lose_bit && !start_i && !stop_i) |=> (!sda_oe_o && state_q == ST_WAIT));

  // R3: acknowledge only with a pending alert
  p_ack_pending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK) |-> pending_i);
endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder
  import smb_alert_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              alert_req_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              alert_drive_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic busy, win;
  logic pending_q, late_q;

  smb_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s_o   (scl_s),
    .sda_s_o   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_c),
    .stop_o    (stop_c)
  );

  smb_resp_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_c),
    .stop_i    (stop_c),
    .pending_i (pending_q),
    .own_addr_i(own_addr_i),
    .sda_oe_o  (sda_oe_o),
    .busy_o    (busy),
    .win_o     (win)
  );

  // late_q remembers requests seen while a response is on the bus
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      late_q    <= 1'b0;
    end else if (win) begin
      pending_q <= alert_req_i | late_q;
      late_q    <= 1'b0;
    end else begin
      if (alert_req_i) pending_q <= 1'b1;
      late_q <= busy ? (late_q | alert_req_i) : 1'b0;
    end
  end

  assign alert_drive_o = pending_q;

  p_req_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_req_i |=> alert_drive_o);

  p_drive_needs_alert_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> alert_drive_o);

  p_clear_on_win_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alert_drive_o) |-> $past(win));
endmodule

// File: tb/tb_smb_alert_responder.sv
module tb_smb_alert_responder;
  localparam int Q = 5;
  localparam int WDOG = 150000;
  localparam int NV = 10;
  // {req, addr_byte, comp_en, comp_addr, own, exp_ack, exp_data, exp_alert}
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 8'h19, 1'b0, 7'h00, 7'h48, 1'b0, 8'h90, 1'b0},
    {1'b0, 8'h19, 1'b0, 7'h00, 7'h48, 1'b1, 8'hFF, 1'b0},
    {1'b1, 8'h18, 1'b0, 7'h00, 7'h48, 1'b1, 8'hFF, 1'b1},
    {1'b0, 8'h2B, 1'b0, 7'h00, 7'h48, 1'b1, 8'hFF, 1'b1},
    {1'b0, 8'h19, 1'b1, 7'h20, 7'h48, 1'b0, 8'h40, 1'b1},
    {1'b0, 8'h19, 1'b1, 7'h50, 7'h48, 1'b0, 8'h90, 1'b0},
    {1'b1, 8'h19, 1'b1, 7'h48, 7'h48, 1'b0, 8'h90, 1'b0},
    {1'b1, 8'h19, 1'b1, 7'h7F, 7'h05, 1'b0, 8'h0A, 1'b0},
    {1'b1, 8'h19, 1'b1, 7'h05, 7'h7F, 1'b0, 8'h0A, 1'b1},
    {1'b0, 8'h19, 1'b0, 7'h00, 7'h7F, 1'b0, 8'hFE, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1, comp_sda = 1'b1;
  logic alert_req = 1'b0;
  logic [6:0] own = 7'h48;
  logic sda_oe, alert_drv;
  wire  sda_bus = sda_h & ~sda_oe & comp_sda;
  int   n_chk = 0, n_fail = 0, viol = 0;
  logic done = 1'b0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  smb_alert_responder dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl_h),
    .sda_i        (sda_bus),
    .sda_oe_o     (sda_oe),
    .alert_req_i  (alert_req),
    .own_addr_i   (own),
    .alert_drive_o(alert_drv)
  );

  // R10 monitor: drive must not move while SCL is high
  always @(negedge clk) begin
    if (scl_h && sda_oe !== oe_prev) viol++;
    oe_prev = sda_oe;
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    alert_req = 1'b1;
    @(negedge clk);
    alert_req = 1'b0;
  endtask

  task automatic send_start();
    sda_h = 1'b1; wait_q();
    scl_h = 1'b1; wait_q();
    sda_h = 1'b0; wait_q();
    scl_h = 1'b0; wait_q();
  endtask

  task automatic send_stop();
    sda_h = 1'b0; wait_q();
    scl_h = 1'b1; wait_q();
    sda_h = 1'b1; wait_q();
  endtask

  task automatic write_bit(input logic b);
    sda_h = b; wait_q();
    scl_h = 1'b1; wait_q(); wait_q();
    scl_h = 1'b0; wait_q();
  endtask

  task automatic read_bit(input logic cb, output logic v);
    sda_h = 1'b1; comp_sda = cb; wait_q();
    scl_h = 1'b1; wait_q();
    v = sda_bus; wait_q();
    scl_h = 1'b0; wait_q();
    comp_sda = 1'b1;
  endtask

  task automatic ara(input logic [7:0] ab, input logic cen, input logic [6:0] caddr,
                     input int stop_after, input int req_at,
                     output logic ack, output logic [7:0] data);
    logic cact;
    logic [7:0] cb;
    logic v;
    send_start();
    for (int i = 7; i >= 0; i--) write_bit(ab[i]);
    cact = cen && (ab == 8'h19);
    read_bit(!cact, ack);
    data = 8'hFF;
    if (!ack) begin
      cb = {caddr, 1'b0};
      for (int k = 0; k < 8; k++) begin
        if (k == stop_after) break;
        if (k == req_at) pulse_req();
        read_bit(cact ? cb[7-k] : 1'b1, v);
        data[7-k] = v;
        if (cact && cb[7-k] && !v) cact = 1'b0;
      end
      if (stop_after >= 8) write_bit(1'b1);
    end
    send_stop();
  endtask

  function automatic void summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endfunction

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] data;
    logic [33:0] v;
    repeat (3) @(negedge clk);
    check("R1 alert after reset", {7'b0, alert_drv}, 8'h00);
    check("R1 sda_oe after reset", {7'b0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    wait_q();

    // R2 pending visible one edge after request
    alert_req = 1'b1;
    @(negedge clk);
    alert_req = 1'b0;
    check("R2 alert after request", {7'b0, alert_drv}, 8'h01);
    own = 7'h48;
    ara(8'h19, 1'b0, 7'h00, 8, 99, ack, data);
    check("R7 alert cleared", {7'b0, alert_drv}, 8'h00);

    // table walk: R3 R4 R5 R6 R7
    for (int n = 0; n < NV; n++) begin
      v = VEC[n];
      own = v[16:10];
      if (v[33]) pulse_req();
      wait_q();
      ara(v[32:25], v[24], v[23:17], 8, 99, ack, data);
      check($sformatf("R3/R4 ack vec%0d", n), {7'b0, ack}, {7'b0, v[9]});
      if (!ack) check($sformatf("R5/R6 data vec%0d", n), data, v[8:1]);
      check($sformatf("R6/R7 alert vec%0d", n), {7'b0, alert_drv}, {7'b0, v[0]});
      check($sformatf("R4 released vec%0d", n), {7'b0, sda_oe}, 8'h00);
    end

    // R8 STOP mid data byte
    own = 7'h7F;
    pulse_req();
    ara(8'h19, 1'b0, 7'h00, 3, 99, ack, data);
    check("R8 ack before abort", {7'b0, ack}, 8'h00);
    check("R8 alert kept after stop", {7'b0, alert_drv}, 8'h01);
    check("R8 sda released", {7'b0, sda_oe}, 8'h00);

    // R8 repeated START mid address byte
    send_start();
    for (int i = 7; i >= 4; i--) write_bit(1'(8'h19 >> i));
    ara(8'h19, 1'b0, 7'h00, 8, 99, ack, data);
    check("R8 ack after restart", {7'b0, ack}, 8'h00);
    check("R8 data after restart", data, 8'hFE);
    check("R8 alert cleared after restart", {7'b0, alert_drv}, 8'h00);

    // R9 request during the data byte
    pulse_req();
    ara(8'h19, 1'b0, 7'h00, 8, 2, ack, data);
    check("R9 data", data, 8'hFE);
    check("R9 alert kept", {7'b0, alert_drv}, 8'h01);
    ara(8'h19, 1'b0, 7'h00, 8, 99, ack, data);
    check("R9 alert cleared next round", {7'b0, alert_drv}, 8'h00);

    // R4 no pending: nothing driven
    ara(8'h19, 1'b0, 7'h00, 8, 99, ack, data);
    check("R4 no ack idle", {7'b0, ack}, 8'h01);

    check("R10 oe moves under SCL high", viol[7:0], 8'h00);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule